// File: doc/BRIEF.md
# Floating-Point Reciprocal Estimate Unit

This unit returns a coarse approximation of 1/x for one IEEE-754 operand in half, single or double precision. It does not divide and does not iterate: the seven most significant fraction bits of the normalised operand index a fixed 128-entry table, and the table entry becomes the top seven fraction bits of the result. The result exponent is formed arithmetically from the input exponent. Zeros, infinities, NaNs, subnormal inputs, results that land in the subnormal range and subnormal inputs whose reciprocal cannot be represented each follow an exact rule. The unit also reports a five-bit exception vector.

The operand arrives on a 64-bit bus. Narrower formats occupy the low bits, and the unused high bits are ignored. A format select and a rounding-mode code travel with the operand. A single registered output stage with a valid/ready handshake holds each result until the consumer takes it, so the unit can sit directly in a pipelined lane and accept a new operand every cycle.

Top module: `rec7_unit`

## Requirements
- R1: Format select 01 is half (5 exponent / 10 fraction bits, operand in bits 15:0), 10 is single (8/23, bits 31:0) and 11 is double (11/52, bits 63:0). The sign sits directly above the exponent. Input bits above the selected format are ignored, and narrower results are zero-extended to 64 bits.
- R2: For finite nonzero results, the top 7 result fraction bits are T(i), where i is the top 7 bits of the normalised input fraction and T(i) = round(65536/(257+2i)) - 128. So T(0)=127 and T(127)=0. The remaining fraction bits are zero.
- R3: For a normal input with biased exponent e, the result exponent is 2^E - 3 - e (E is the exponent width). The result sign always equals the input sign.
- R4: When that exponent is 0, the result fraction is the table fraction shifted right once with a 1 placed in its MSB. When it is -1, the result is shifted right once more and the exponent becomes 0. Neither case raises a flag, and the underflow flag is never raised.
- R5: A subnormal input is normalised by left-shifting its fraction, with a working exponent that starts at 0 and drops by one per shift, until the MSB is 1. One more left shift discards that 1. The working exponent then takes the place of e in R3.
- R6: A subnormal input that needs two or more normalising shifts overflows, and the flags are overflow and inexact (00101). The result is the largest finite magnitude with the input's sign when the rounding code is 001 (toward zero), 010 (down) with a positive input, or 011 (up) with a negative input. For 000 (nearest even), 100 (nearest, ties away) and the remaining sign cases, the result is infinity with the input's sign.
- R7: Infinity gives zero of the same sign with no flags. Zero gives infinity of the same sign with flags 01000 (divide by zero).
- R8: Any NaN input gives the canonical NaN of the format (7E00, 7FC00000, 7FF8000000000000 hexadecimal). A signalling NaN (fraction MSB clear) raises invalid (10000); a quiet NaN raises no flag.
- R9: Format select 00 is reserved and yields 7FC00000 hexadecimal with the invalid flag (10000).
- R10: The output stage loads when in_valid and in_ready are both high. in_ready is high when out_valid is low or out_ready is high. While out_valid is high and out_ready is low, the result and flags stay unchanged.
- R11: A synchronous active-low reset clears out_valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Unit can take an operand this cycle |
| in_op | input | 64 | Operand, narrower formats in the low bits |
| in_fmt | input | 2 | Format select: 01 half, 10 single, 11 double, 00 reserved |
| in_rm | input | 3 | Rounding-mode code |
| out_valid | output | 1 | Result held in the output stage |
| out_ready | input | 1 | Consumer takes the result |
| out_res | output | 64 | Reciprocal estimate, zero-extended |
| out_flags | output | 5 | {invalid, divide-by-zero, overflow, underflow, inexact} |

## Verification
The bench drives inputs whose exponent sits at the top of the normal range. These produce result exponents of 0 and -1, where a design that skips the extra right shift or the inserted leading 1 returns a value twice as large or missing its hidden bit. Subnormal inputs needing exactly zero, one and two normalising shifts are run against every rounding code and both signs. An off-by-one in the overflow threshold turns a valid estimate into infinity, and a swapped sign condition clamps the wrong direction. The full table is walked in single precision, so a wrong entry or an index taken from the wrong fraction bits shows up. Backpressure, reserved formats, NaN kinds and garbage in the unused high operand bits are also covered, exposing a design that overwrites a held result or fails to mask the unused bits.

// File: rtl/rec7_pkg.sv
// Package: shared widths, codes and constant functions of the reciprocal
// estimate unit. Assumes the three IEEE-754 binary formats only.
package rec7_pkg;

    localparam int WORD_W    = 64;
    localparam int FRAC_W    = 52;                 // widest fraction
    localparam int EXP_W     = 11;                 // widest exponent
    localparam int WEXP_W    = EXP_W + 2;          // signed working exponent
    localparam int LUT_BITS  = 7;
    localparam int LUT_DEPTH = 1 << LUT_BITS;
    localparam int LZ_W      = $clog2(FRAC_W + 1);
    localparam int FLAG_W    = 5;

    typedef enum logic [1:0] {
        FMT_RSVD = 2'b00,
        FMT_HALF = 2'b01,
        FMT_SNGL = 2'b10,
        FMT_DBL  = 2'b11
    } fmt_e;

    typedef enum logic [2:0] {
        RM_RNE = 3'b000,
        RM_RTZ = 3'b001,
        RM_RDN = 3'b010,
        RM_RUP = 3'b011,
        RM_RMM = 3'b100
    } rm_e;

    typedef enum logic [2:0] {
        CL_ZERO, CL_SUB, CL_NORM, CL_INF, CL_QNAN, CL_SNAN, CL_BAD
    } cls_e;

    localparam logic [FLAG_W-1:0] FLG_NV = 5'b10000;
    localparam logic [FLAG_W-1:0] FLG_DZ = 5'b01000;
    localparam logic [FLAG_W-1:0] FLG_OF = 5'b00100;
    localparam logic [FLAG_W-1:0] FLG_NX = 5'b00001;

    // Exponent width of a format.
    function automatic int exp_bits(fmt_e f);
        case (f)
            FMT_HALF: return 5;
            FMT_DBL:  return 11;
            default:  return 8;
        endcase
    endfunction

    // Canonical quiet NaN of a format, zero-extended.
    function automatic logic [WORD_W-1:0] canon_nan(fmt_e f);
        case (f)
            FMT_HALF: return 64'h0000_0000_0000_7E00;
            FMT_DBL:  return 64'h7FF8_0000_0000_0000;
            default:  return 64'h0000_0000_7FC0_0000;
        endcase
    endfunction

    // Table entry i: round(2^(2L+2) / (2^(L+1) + 2i + 1)) - 2^L.
    function automatic logic [LUT_BITS-1:0] lut_entry(int i);
        int num;
        int den;
        num = 1 << (2 * LUT_BITS + 2);
        den = (1 << (LUT_BITS + 1)) + 2 * i + 1;
        return LUT_BITS'((2 * num + den) / (2 * den) - (1 << LUT_BITS));
    endfunction

    // Leading-zero count of a left-aligned fraction.
    function automatic logic [LZ_W-1:0] lzc(logic [FRAC_W-1:0] v);
        logic [LZ_W-1:0] n;
        logic            hit;
        n   = LZ_W'(FRAC_W);
        hit = 1'b0;
        for (int i = FRAC_W - 1; i >= 0; i--) begin
            if (!hit && v[i]) begin
                n   = LZ_W'(FRAC_W - 1 - i);
                hit = 1'b1;
            end
        end
        return n;
    endfunction

    // Place sign, exponent and left-aligned fraction into a format word.
    function automatic logic [WORD_W-1:0] assemble(fmt_e f, logic s,
                                                   logic [EXP_W-1:0] e,
                                                   logic [FRAC_W-1:0] m);
        case (f)
            FMT_HALF: return {48'b0, s, e[4:0], m[FRAC_W-1 -: 10]};
            FMT_DBL:  return {s, e, m};
            default:  return {32'b0, s, e[7:0], m[FRAC_W-1 -: 23]};
        endcase
    endfunction

endpackage

// File: rtl/rec7_classify.sv
// Splits the operand by format into sign, exponent and a left-aligned
// 52-bit fraction, and classifies it. Assumes a reserved format code
// is reported as CL_BAD and its fields are don't-care.
module rec7_classify
    import rec7_pkg::*;
(
    input  fmt_e               fmt_i,
    input  logic [WORD_W-1:0]  op_i,
    output logic               sign_o,
    output logic [EXP_W-1:0]   exp_o,
    output logic [FRAC_W-1:0]  frac_o,
    output cls_e               cls_o
);

    logic [EXP_W-1:0] all_ones;

    // Field extraction per format, fraction left-aligned.
    always_comb begin
        case (fmt_i)
            FMT_HALF: begin
                sign_o = op_i[15];
                exp_o  = {6'b0, op_i[14:10]};
                frac_o = {op_i[9:0], 42'b0};
            end
            FMT_SNGL: begin
                sign_o = op_i[31];
                exp_o  = {3'b0, op_i[30:23]};
                frac_o = {op_i[22:0], 29'b0};
            end
            FMT_DBL: begin
                sign_o = op_i[63];
                exp_o  = op_i[62:52];
                frac_o = op_i[51:0];
            end
            default: begin
                sign_o = 1'b0;
                exp_o  = '0;
                frac_o = '0;
            end
        endcase
    end

    // Operand class from the extracted fields.
    always_comb begin
        all_ones = EXP_W'((1 << exp_bits(fmt_i)) - 1);
        if (fmt_i == FMT_RSVD)           cls_o = CL_BAD;
        else if (exp_o == '0)            cls_o = (frac_o == '0) ? CL_ZERO : CL_SUB;
        else if (exp_o == all_ones) begin
            if (frac_o == '0)            cls_o = CL_INF;
            else if (frac_o[FRAC_W-1])   cls_o = CL_QNAN;
            else                         cls_o = CL_SNAN;
        end
        else                             cls_o = CL_NORM;
    end

endmodule

// File: rtl/rec7_normalize.sv
// Produces the table index and signed working exponent. Subnormals are
// normalised with a leading-zero count; two or more shifts flag an
// unrepresentable reciprocal. Assumes the fraction is nonzero when sub_i.
module rec7_normalize
    import rec7_pkg::*;
(
    input  logic                     sub_i,
    input  logic [EXP_W-1:0]         exp_i,
    input  logic [FRAC_W-1:0]        frac_i,
    output logic [LUT_BITS-1:0]      idx_o,
    output logic signed [WEXP_W-1:0] wexp_o,
    output logic                     huge_o
);

    logic [LZ_W-1:0] lz;

    // Leading-zero count over the aligned fraction.
    assign lz = lzc(frac_i);

    // Index and working exponent for normal or subnormal operands.
    always_comb begin
        if (sub_i) begin
            idx_o  = LUT_BITS'((frac_i << (lz + LZ_W'(1))) >> (FRAC_W - LUT_BITS));
            wexp_o = -$signed({{(WEXP_W-LZ_W){1'b0}}, lz});
            huge_o = (lz >= LZ_W'(2));
        end else begin
            idx_o  = frac_i[FRAC_W-1 -: LUT_BITS];
            wexp_o = $signed({2'b00, exp_i});
            huge_o = 1'b0;
        end
    end

endmodule

// File: rtl/rec7_core.sv
// Table lookup and result exponent, including right shifts for results
// whose exponent computes to 0 or -1. The table is generated at
// elaboration from the package function. Assumes a finite nonzero input.
module rec7_core
    import rec7_pkg::*;
(
    input  fmt_e                     fmt_i,
    input  logic [LUT_BITS-1:0]      idx_i,
    input  logic signed [WEXP_W-1:0] wexp_i,
    output logic [EXP_W-1:0]         oexp_o,
    output logic [FRAC_W-1:0]        ofrac_o
);

    logic [LUT_BITS-1:0]      lut [LUT_DEPTH];
    logic signed [WEXP_W-1:0] bias2m1;
    logic signed [WEXP_W-1:0] oe;
    logic [FRAC_W-1:0]        base;

    // One constant table entry per index.
    for (genvar g = 0; g < LUT_DEPTH; g++) begin : g_lut
        assign lut[g] = lut_entry(g);
    end

    // Exponent arithmetic and subnormal-result shifting.
    always_comb begin
        bias2m1 = WEXP_W'((1 << exp_bits(fmt_i)) - 3);
        oe      = bias2m1 - wexp_i;
        base    = {lut[idx_i], {(FRAC_W-LUT_BITS){1'b0}}};
        if (oe == '0) begin
            oexp_o  = '0;
            ofrac_o = {1'b1, base[FRAC_W-1:1]};
        end else if (oe == -1) begin
            oexp_o  = '0;
            ofrac_o = {2'b01, base[FRAC_W-1:2]};
        end else begin
            oexp_o  = oe[EXP_W-1:0];
            ofrac_o = base;
        end
    end

endmodule

// File: rtl/rec7_pack.sv
// Selects the final word and flags from the operand class, the overflow
// indication and the rounding code, and packs it for the format.
module rec7_pack
    import rec7_pkg::*;
(
    input  fmt_e               fmt_i,
    input  logic [2:0]         rm_i,
    input  logic               sign_i,
    input  cls_e               cls_i,
    input  logic               huge_i,
    input  logic [EXP_W-1:0]   oexp_i,
    input  logic [FRAC_W-1:0]  ofrac_i,
    output logic [WORD_W-1:0]  res_o,
    output logic [FLAG_W-1:0]  flags_o
);

    logic [EXP_W-1:0] all_ones;
    logic             clamp;

    // Overflow saturates to max finite for directed-toward-zero cases.
    always_comb begin
        clamp = (rm_i == RM_RTZ) ||
                (rm_i == RM_RDN && !sign_i) ||
                (rm_i == RM_RUP &&  sign_i);
    end

    // Result and flag selection by class.
    always_comb begin
        all_ones = EXP_W'((1 << exp_bits(fmt_i)) - 1);
        flags_o  = '0;
        case (cls_i)
            CL_BAD: begin
                res_o   = canon_nan(FMT_SNGL);
                flags_o = FLG_NV;
            end
            CL_SNAN: begin
                res_o   = canon_nan(fmt_i);
                flags_o = FLG_NV;
            end
            CL_QNAN: res_o = canon_nan(fmt_i);
            CL_INF:  res_o = assemble(fmt_i, sign_i, '0, '0);
            CL_ZERO: begin
                res_o   = assemble(fmt_i, sign_i, all_ones, '0);
                flags_o = FLG_DZ;
            end
            default: begin
                if (huge_i) begin
                    flags_o = FLG_OF | FLG_NX;
                    res_o   = clamp ? assemble(fmt_i, sign_i, all_ones - EXP_W'(1), '1)
                                    : assemble(fmt_i, sign_i, all_ones, '0);
                end else begin
                    res_o = assemble(fmt_i, sign_i, oexp_i, ofrac_i);
                end
            end
        endcase
    end

endmodule

// File: rtl/rec7_unit.sv
// Top of the reciprocal estimate unit: combinational estimate path feeding
// one registered output stage with a valid/ready handshake.
// Assumes synchronous active-low reset; data registers are not reset.
module rec7_unit
    import rec7_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [WORD_W-1:0]   in_op,
    input  logic [1:0]          in_fmt,
    input  logic [2:0]          in_rm,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [WORD_W-1:0]   out_res,
    output logic [FLAG_W-1:0]   out_flags
);

    fmt_e                     fmt;
    logic                     sgn;
    logic [EXP_W-1:0]         iexp;
    logic [FRAC_W-1:0]        ifrac;
    cls_e                     cls;
    logic [LUT_BITS-1:0]      idx;
    logic signed [WEXP_W-1:0] wexp;
    logic                     huge;
    logic [EXP_W-1:0]         oexp;
    logic [FRAC_W-1:0]        ofrac;
    logic [WORD_W-1:0]        res_d;
    logic [FLAG_W-1:0]        flags_d;
    logic                     take;

    assign fmt      = fmt_e'(in_fmt);
    assign in_ready = !out_valid || out_ready;
    assign take     = in_valid && in_ready;

    rec7_classify u_classify (
        .fmt_i  (fmt),
        .op_i   (in_op),
        .sign_o (sgn),
        .exp_o  (iexp),
        .frac_o (ifrac),
        .cls_o  (cls)
    );

    rec7_normalize u_normalize (
        .sub_i  (cls == CL_SUB),
        .exp_i  (iexp),
        .frac_i (ifrac),
        .idx_o  (idx),
        .wexp_o (wexp),
        .huge_o (huge)
    );

    rec7_core u_core (
        .fmt_i   (fmt),
        .idx_i   (idx),
        .wexp_i  (wexp),
        .oexp_o  (oexp),
        .ofrac_o (ofrac)
    );

    rec7_pack u_pack (
        .fmt_i   (fmt),
        .rm_i    (in_rm),
        .sign_i  (sgn),
        .cls_i   (cls),
        .huge_i  (huge),
        .oexp_i  (oexp),
        .ofrac_i (ofrac),
        .res_o   (res_d),
        .flags_o (flags_d)
    );

    // Output valid: set on accept, cleared when drained or in reset.
    always_ff @(posedge clk) begin
        if (!rst_n)         out_valid <= 1'b0;
        else if (take)      out_valid <= 1'b1;
        else if (out_ready) out_valid <= 1'b0;
    end

    // Output data: captured only on accept.
    always_ff @(posedge clk) begin
        if (take) begin
            out_res   <= res_d;
            out_flags <= flags_d;
        end
    end

endmodule

// File: rtl/rec7_unit_chk.sv
// Checker for rec7_unit: handshake and flag-combination properties on
// the top-level ports. Attached by the bind at the end of this file.
module rec7_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [63:0] out_res,
    input logic [4:0]  out_flags
);

    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> !out_valid); // R11

    AST_ACCEPT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid); // R10

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_res) && $stable(out_flags)); // R10

    AST_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !in_valid |=> !out_valid); // R10

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !out_flags[1]); // R4

    AST_OVF_WITH_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_flags[2] == out_flags[0]); // R6

    AST_DZ_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_flags[3] |-> out_flags == 5'b01000); // R7

endmodule

bind rec7_unit rec7_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_res   (out_res),
    .out_flags (out_flags)
);

// File: tb/rec7_unit_bench.sv
`timescale 1ns/1ps
module rec7_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] in_op = '0;
    logic [1:0]  in_fmt = 2'b10;
    logic [2:0]  in_rm = 3'b000;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [63:0] out_res;
    logic [4:0]  out_flags;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    rec7_unit u_rec7_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_op     (in_op),
        .in_fmt    (in_fmt),
        .in_rm     (in_rm),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_res   (out_res),
        .out_flags (out_flags)
    );

    // Table value from the R2 formula.
    function automatic longint unsigned tbl(int i);
        int d;
        d = 257 + 2 * i;
        return longint'((131072 + d) / (2 * d) - 128);
    endfunction

    // Expected result and flags from the requirements.
    function automatic void ref_model(input logic [1:0] fmt, input logic [63:0] op,
                                      input logic [2:0] rm,
                                      output logic [63:0] res, output logic [4:0] fl);
        int E, F;
        longint unsigned s, e, f, ones, fmask, ofr;
        longint w, oe;
        int idx;
        fl = 5'b0;
        if (fmt == 2'b00) begin res = 64'h7FC00000; fl = 5'b10000; return; end
        E = (fmt == 2'b01) ? 5 : (fmt == 2'b10) ? 8 : 11;
        F = (fmt == 2'b01) ? 10 : (fmt == 2'b10) ? 23 : 52;
        fmask = (64'd1 << F) - 1;
        ones  = (64'd1 << E) - 1;
        f = op & fmask;
        e = (op >> F) & ones;
        s = (op >> (E + F)) & 1;
        if (e == ones) begin
            if (f == 0) begin res = s << (E + F); return; end
            res = (fmt == 2'b01) ? 64'h7E00 : (fmt == 2'b10) ? 64'h7FC00000 : 64'h7FF8000000000000;
            if (((f >> (F - 1)) & 1) == 0) fl = 5'b10000;
            return;
        end
        if (e == 0 && f == 0) begin
            res = (s << (E + F)) | (ones << F); fl = 5'b01000; return;
        end
        w = longint'(e);
        if (e == 0) begin
            while (((f >> (F - 1)) & 1) == 0) begin w--; f = f << 1; end
            f = (f << 1) & fmask;
            if (w < -1) begin
                fl = 5'b00101;
                if (rm == 3'b001 || (rm == 3'b010 && s == 0) || (rm == 3'b011 && s == 1))
                    res = (s << (E + F)) | ((ones - 1) << F) | fmask;
                else
                    res = (s << (E + F)) | (ones << F);
                return;
            end
        end
        idx = int'(f >> (F - 7));
        ofr = tbl(idx) << (F - 7);
        oe  = longint'((1 << E) - 3) - w;
        if (oe == 0 || oe == -1) begin
            ofr = (ofr >> 1) | (64'd1 << (F - 1));
            if (oe == -1) begin ofr = ofr >> 1; oe = 0; end
        end
        res = (s << (E + F)) | (longint'(oe) << F) | ofr;
    endfunction

    task automatic chk(string req, logic [69:0] act, logic [69:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One operand through the stage with out_ready high, checked by model.
    task automatic run_op(logic [1:0] fmt, logic [63:0] op, logic [2:0] rm, string req);
        logic [63:0] er;
        logic [4:0]  ef;
        @(negedge clk);
        in_valid = 1'b1; in_fmt = fmt; in_op = op; in_rm = rm;
        @(negedge clk);
        in_valid = 1'b0;
        ref_model(fmt, op, rm, er, ef);
        chk(req, {out_valid, out_flags, out_res}, {1'b1, ef, er});
    endtask

    // Same, against a hand-worked value.
    task automatic run_fix(logic [1:0] fmt, logic [63:0] op, logic [2:0] rm,
                           logic [63:0] er, logic [4:0] ef, string req);
        @(negedge clk);
        in_valid = 1'b1; in_fmt = fmt; in_op = op; in_rm = rm;
        @(negedge clk);
        in_valid = 1'b0;
        chk(req, {out_valid, out_flags, out_res}, {1'b1, ef, er});
    endtask

    // Random operand of a chosen class for a format.
    function automatic logic [63:0] make_op(logic [1:0] fmt, int cls);
        int E, F;
        longint unsigned s, e, f, fmask, ones, r;
        E = (fmt == 2'b01) ? 5 : (fmt == 2'b10) ? 8 : 11;
        F = (fmt == 2'b01) ? 10 : (fmt == 2'b10) ? 23 : 52;
        fmask = (64'd1 << F) - 1;
        ones  = (64'd1 << E) - 1;
        r = {$urandom, $urandom};
        s = longint'($urandom % 2);
        f = r & fmask;
        case (cls)
            0: e = 1 + longint'($urandom % 32'(ones - 1));
            1: begin
                e = 0;
                f = f >> ($urandom % 32'(F));
                if (f == 0) f = 1;
            end
            default: begin
                e = ones;
                case ($urandom % 4)
                    0: f = 0;
                    1: e = 0;
                    2: f = f | (64'd1 << (F - 1));
                    default: begin f = f & (fmask >> 1); if (f == 0) f = 1; end
                endcase
                if (e == 0) f = 0;
            end
        endcase
        r = {$urandom, $urandom};
        if (fmt == 2'b11) return (s << (E + F)) | (e << F) | f;
        return (r << (E + F + 1)) | (s << (E + F)) | (e << F) | f;
    endfunction

    // Watchdog: a hung run is a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20211208));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R11 reset", {69'b0, out_valid}, 70'b0);
        rst_n = 1'b1;

        // R1 field layout, zero-extension, ignored upper bits
        run_fix(2'b01, 64'h0000_0000_0000_3C00, 3'b000, 64'h3BF8, 5'b0, "R1 half 1.0");
        run_fix(2'b01, 64'hDEAD_BEEF_0000_3C00, 3'b000, 64'h3BF8, 5'b0, "R1 half upper garbage");
        run_fix(2'b11, 64'h3FF0_0000_0000_0000, 3'b000, 64'h3FEF_E000_0000_0000, 5'b0, "R1 double 1.0");
        // R2 table ends, R3 exponent and sign
        run_fix(2'b10, 64'h3F80_0000, 3'b000, 64'h3F7F_0000, 5'b0, "R2 T(0)");
        run_fix(2'b10, 64'hBFFF_FFFF, 3'b000, 64'hBF00_0000, 5'b0, "R2 T(127) negative R3");
        for (int i = 0; i < 128; i++)
            run_op(2'b10, 64'h3F80_0000 | (64'(i) << 16), 3'b000, "R2 table walk");
        // R4 denormalised results
        run_fix(2'b10, 64'h7F00_0000, 3'b000, 64'h003F_C000, 5'b0, "R4 exponent -1");
        run_op(2'b10, 64'h7E80_0000, 3'b000, "R4 exponent 0");
        run_op(2'b01, 64'h7BFF, 3'b011, "R4 half max normal");
        run_op(2'b11, 64'hFFEF_FFFF_FFFF_FFFF, 3'b000, "R4 double max normal");
        // R5 subnormal normalisation with 0 and 1 shifts
        run_fix(2'b10, 64'h0040_0000, 3'b000, 64'h7EFF_0000, 5'b0, "R5 zero shifts");
        run_fix(2'b10, 64'h0020_0000, 3'b000, 64'h7F7F_0000, 5'b0, "R5 one shift");
        // R6 overflow across rounding codes and signs
        run_fix(2'b10, 64'h0000_0001, 3'b001, 64'h7F7F_FFFF, 5'b00101, "R6 rtz");
        run_fix(2'b10, 64'h0000_0001, 3'b000, 64'h7F80_0000, 5'b00101, "R6 rne");
        run_fix(2'b10, 64'h0010_0000, 3'b010, 64'h7F7F_FFFF, 5'b00101, "R6 down positive");
        run_fix(2'b10, 64'h8000_0001, 3'b010, 64'hFF80_0000, 5'b00101, "R6 down negative");
        run_fix(2'b10, 64'h8000_0001, 3'b011, 64'hFF7F_FFFF, 5'b00101, "R6 up negative");
        run_fix(2'b10, 64'h0000_0001, 3'b100, 64'h7F80_0000, 5'b00101, "R6 rmm");
        // R7 infinities and zeros
        run_fix(2'b10, 64'h7F80_0000, 3'b000, 64'h0, 5'b0, "R7 +inf");
        run_fix(2'b10, 64'h8000_0000, 3'b000, 64'hFF80_0000, 5'b01000, "R7 -zero");
        run_fix(2'b01, 64'h8000, 3'b000, 64'hFC00, 5'b01000, "R7 half -zero");
        // R8 NaNs
        run_fix(2'b10, 64'h7F80_0001, 3'b000, 64'h7FC0_0000, 5'b10000, "R8 snan single");
        run_fix(2'b01, 64'hFC01, 3'b000, 64'h7E00, 5'b10000, "R8 snan half");
        run_fix(2'b11, 64'hFFF8_0000_0000_0001, 3'b000, 64'h7FF8_0000_0000_0000, 5'b0, "R8 qnan double");
        // R9 reserved format
        run_fix(2'b00, 64'h3F80_0000, 3'b000, 64'h7FC0_0000, 5'b10000, "R9 reserved");

        // R10 backpressure: held result, in_ready low, then replacement
        @(negedge clk);
        out_ready = 1'b0;
        in_valid = 1'b1; in_fmt = 2'b10; in_op = 64'h3F80_0000; in_rm = 3'b000;
        @(negedge clk);
        in_op = 64'h7F80_0000;
        chk("R10 held first, ready low", {out_valid, in_ready, out_flags, out_res[62:0]},
            {1'b1, 1'b0, 5'b0, 63'h3F7F_0000});
        @(negedge clk);
        chk("R10 still held", {out_valid, in_ready, out_flags, out_res[62:0]},
            {1'b1, 1'b0, 5'b0, 63'h3F7F_0000});
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R10 replaced after accept", {out_valid, out_flags, out_res}, {1'b1, 5'b0, 64'h0});
        @(negedge clk);
        chk("R10 drained", {69'b0, out_valid}, 70'b0);

        // R11 reset while a result is held
        out_ready = 1'b0;
        in_valid = 1'b1; in_op = 64'h3F80_0000;
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R11 reset clears held", {69'b0, out_valid}, 70'b0);
        rst_n = 1'b1;
        out_ready = 1'b1;

        // Random mix: R3 normals, R5 subnormals, R8 specials, R9 reserved
        for (int n = 0; n < 800; n++) begin
            logic [1:0] fmt;
            int         cls;
            logic [2:0] rm;
            fmt = 2'($urandom % 4);
            if ($urandom % 16 != 0 && fmt == 2'b00) fmt = 2'b10;
            cls = int'($urandom % 3);
            rm  = 3'($urandom % 5);
            if (fmt == 2'b00)   run_op(fmt, {$urandom, $urandom}, rm, "R9 random");
            else if (cls == 0)  run_op(fmt, make_op(fmt, 0), rm, "R3 random normal");
            else if (cls == 1)  run_op(fmt, make_op(fmt, 1), rm, "R5 random subnormal");
            else                run_op(fmt, make_op(fmt, 2), rm, "R8 random special");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule